// File: doc/BRIEF.md
# Dual-Slope PWM Timer Channel

This block is a 16-bit timer that counts up from zero to a programmable turning value (TOP) and then back down to zero, over and over. Each compare channel drives one output pin whose level follows the relation between the count and the channel's compare value. The up and down slopes are identical, so each high pulse sits centred on the bottom turning point. This symmetry makes the block a good fit for motor and power-stage control. The output frequency is the clock divided by 2·N·TOP, where N is the prescaler ratio.

Compare values and the TOP source are double-buffered. A write lands in a buffer, and the live value changes only when the counter leaves zero. A new duty cycle or period therefore always starts on a clean period boundary. Sticky flags record compare matches and both turning points. A write-one pulse clears them. All pins are plain control and status signals. Nothing streams in or out of the block, so there is no back-pressure to manage.

Top module: `pwm_dual_slope_timer`

## Requirements
- R1: On each count tick the counter moves by exactly one. Going up it moves from 0 to TOP, holds TOP for exactly one tick, then goes down to 0 and turns up again, so one period is 2·TOP ticks. Without a tick the count does not change.
- R2: With `top_src_sel`=0, TOP comes from the dedicated TOP register. With `top_src_sel`=1, TOP comes from channel 0's compare value. TOP is sampled on the tick that leaves count 0, and a value below 3 is treated as 3. The count never exceeds the TOP in use.
- R3: `presc_sel` sets the tick rate: 1 gives every clock, 2 gives one tick in 8 clocks, 3 one in 64, 4 one in 256, 5 one in 1024, and 0, 6 or 7 stop the counter.
- R4: A compare write (`cmp_wr[i]`, data in `cmp_wdata[16i+15:16i]`) only fills channel i's buffer. The live compare value takes the buffer only on the tick that leaves count 0.
- R5: Output mode 2 (non-inverting) clears the pin on the tick leaving a count equal to the compare value while counting up. It sets the pin on the tick leaving that count while counting down. This gives 2·C high clocks per period for 0<C<TOP at a tick rate of one per clock.
- R6: Output mode 3 (inverting) drives the complement of mode 2: 2·(TOP−C) high clocks per period.
- R7: A compare value of 0 holds the pin low in mode 2 and high in mode 3. A compare value at or above TOP holds it high in mode 2 and low in mode 3.
- R8: Output mode 1 (toggle) inverts the pin on every tick leaving a matching count. With channel 0 defining TOP in this mode, pin 0 toggles once per period, giving a 50% duty cycle.
- R9: Output mode 0 (disconnected) holds the pin low. The mode of channel i is `out_mode[2i+1:2i]`.
- R10: A channel's match flag is set by a tick taken while the count equals its live compare value. It stays set until a one on `match_clr[i]` clears it, and a set in the same cycle wins.
- R11: `top_flag_o` is set when the counter turns at TOP, and `bot_flag_o` is set when it turns at zero after a down slope. Each flag stays set until its clear input is pulsed.
- R12: Synchronous active-high `rst` zeroes the count, selects up-counting, clears all flags, buffers and live compare values, drives all pins low and loads 0xFFFF into the TOP register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| presc_sel | input | 3 | Tick rate select |
| top_src_sel | input | 1 | TOP source: 0 TOP register, 1 channel 0 compare |
| top_wr | input | 1 | Write strobe for the TOP register |
| top_wdata | input | 16 | TOP register write data |
| cmp_wr | input | NCH | Per-channel compare buffer write strobe |
| cmp_wdata | input | 16·NCH | Compare write data, channel i at bits 16i+15:16i |
| out_mode | input | 2·NCH | Output mode per channel |
| match_clr | input | NCH | Write-one clear of the match flags |
| top_flag_clr | input | 1 | Write-one clear of the TOP flag |
| bot_flag_clr | input | 1 | Write-one clear of the bottom flag |
| count_o | output | 16 | Current count |
| count_down_o | output | 1 | Direction: 1 while on the down slope |
| pwm_o | output | NCH | Compare output pins |
| match_flag_o | output | NCH | Sticky compare match flags |
| top_flag_o | output | 1 | Sticky TOP turning flag |
| bot_flag_o | output | 1 | Sticky bottom turning flag |

## Verification
The cycle assertions check the properties that are local in time. They confirm the single-step movement of the counter, that it holds still when no tick arrives, and that it turns exactly at TOP and stays within range. They also cover the spacing of prescaler ticks, the stability of live compare values between bottom points, the constant levels at the compare extremes, and the stickiness of the flags. Duty-cycle counts per period need the bench's scenarios to show them, and so do the 50% toggle case, the delayed take-up of a buffered compare value and the exact tick intervals of each divide ratio.

// File: rtl/pwm_dual_pkg.sv
package pwm_dual_pkg;

  typedef enum logic [1:0] {
    OUT_OFF    = 2'd0,
    OUT_TOGGLE = 2'd1,
    OUT_NONINV = 2'd2,
    OUT_INV    = 2'd3
  } out_mode_e;

  // Smallest TOP the counter will accept
  localparam int unsigned MIN_TOP = 3;

  // Prescaler select codes
  localparam logic [2:0] PRE_DIV1    = 3'd1;
  localparam logic [2:0] PRE_DIV8    = 3'd2;
  localparam logic [2:0] PRE_DIV64   = 3'd3;
  localparam logic [2:0] PRE_DIV256  = 3'd4;
  localparam logic [2:0] PRE_DIV1024 = 3'd5;

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_dual_pkg::*;
#(
  parameter int PRE_W = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] sel,
  output logic       tick
);
  localparam int SH8   = 3;
  localparam int SH64  = 6;
  localparam int SH256 = 8;

  logic [PRE_W-1:0] pc;

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc + PRE_W'(1);
  end

  always_comb begin
    case (sel)
      PRE_DIV1:    tick = 1'b1;
      PRE_DIV8:    tick = &pc[SH8-1:0];
      PRE_DIV64:   tick = &pc[SH64-1:0];
      PRE_DIV256:  tick = &pc[SH256-1:0];
      PRE_DIV1024: tick = &pc;
      default:     tick = 1'b0;
    endcase
  end

  // R3: a divide-by-8 tick is never followed by another one at once
  p_div8_gap_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && sel == PRE_DIV8) |=> (sel != PRE_DIV8 || !tick));

endmodule

// File: rtl/pwm_updown_counter.sv
module pwm_updown_counter
  import pwm_dual_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         top_src_sel,
  input  logic [W-1:0] top_reg_val,
  input  logic [W-1:0] cmpa_buf,
  output logic [W-1:0] cnt,
  output logic [W-1:0] top_cur,
  output logic         dir_down,
  output logic         load,
  output logic         top_turn,
  output logic         bot_turn
);
  localparam logic [W-1:0] TOP_FLOOR = W'(MIN_TOP);

  logic [W-1:0] top_act;
  logic [W-1:0] top_raw;
  logic [W-1:0] top_new;

  always_comb begin
    top_raw  = top_src_sel ? cmpa_buf : top_reg_val;
    top_new  = (top_raw < TOP_FLOOR) ? TOP_FLOOR : top_raw;
    load     = tick && (cnt == '0);
    top_cur  = load ? top_new : top_act;
    top_turn = tick && !dir_down && (cnt >= top_act);
    bot_turn = load && dir_down;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      dir_down <= 1'b0;
      top_act  <= TOP_FLOOR;
    end else if (tick) begin
      if (cnt == '0) begin
        cnt      <= W'(1);
        dir_down <= 1'b0;
        top_act  <= top_new;
      end else if (!dir_down && cnt >= top_act) begin
        cnt      <= cnt - W'(1);
        dir_down <= 1'b1;
      end else if (dir_down) begin
        cnt <= cnt - W'(1);
      end else begin
        cnt <= cnt + W'(1);
      end
    end
  end

  p_step_r1: assert property (@(posedge clk) disable iff (rst)
    tick |=> (cnt == $past(cnt) + W'(1)) || (cnt == $past(cnt) - W'(1)));

  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));

  p_turn_at_top_r1: assert property (@(posedge clk) disable iff (rst)
    top_turn |=> dir_down && (cnt == $past(cnt) - W'(1)));

  p_in_range_r2: assert property (@(posedge clk) disable iff (rst)
    cnt <= top_act);

  p_top_floor_r2: assert property (@(posedge clk) disable iff (rst)
    top_act >= TOP_FLOOR);

endmodule

// File: rtl/pwm_compare_ch.sv
module pwm_compare_ch
  import pwm_dual_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         load,
  input  logic         dir_down,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] top_cur,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic [1:0]   mode,
  input  logic         flag_clr,
  output logic [W-1:0] buf_q,
  output logic         pin,
  output logic         flag
);
  out_mode_e    m;
  logic [W-1:0] act;
  logic [W-1:0] cmp_cur;
  logic         match;
  logic         lvl_set;
  logic         lvl_val;

  assign m = out_mode_e'(mode);

  always_comb begin
    cmp_cur = load ? buf_q : act;
    match   = (cnt == cmp_cur);
    lvl_set = 1'b1;
    if (cmp_cur == '0) begin
      lvl_val = 1'b0;
    end else if (cmp_cur >= top_cur) begin
      lvl_val = 1'b1;
    end else if (match) begin
      lvl_val = dir_down;
    end else begin
      lvl_set = 1'b0;
      lvl_val = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q <= '0;
      act   <= '0;
      pin   <= 1'b0;
      flag  <= 1'b0;
    end else begin
      if (wr)   buf_q <= wdata;
      if (load) act   <= buf_q;

      if (tick && match) flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;

      case (m)
        OUT_OFF:    pin <= 1'b0;
        OUT_TOGGLE: if (tick && match)   pin <= ~pin;
        OUT_NONINV: if (tick && lvl_set) pin <= lvl_val;
        OUT_INV:    if (tick && lvl_set) pin <= ~lvl_val;
        default:    pin <= 1'b0;
      endcase
    end
  end

  p_live_stable_r4: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(act));

  p_off_low_r9: assert property (@(posedge clk) disable iff (rst)
    (m == OUT_OFF) |=> !pin);

  p_zero_low_r7: assert property (@(posedge clk) disable iff (rst)
    (tick && m == OUT_NONINV && cmp_cur == '0) |=> !pin);

  p_full_inv_low_r7: assert property (@(posedge clk) disable iff (rst)
    (tick && m == OUT_INV && cmp_cur != '0 && cmp_cur >= top_cur) |=> !pin);

  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (flag && !flag_clr) |=> flag);

  p_flag_set_r10: assert property (@(posedge clk) disable iff (rst)
    (tick && match) |=> flag);

endmodule

// File: rtl/pwm_dual_slope_timer.sv
module pwm_dual_slope_timer
  import pwm_dual_pkg::*;
#(
  parameter int NCH   = 2,
  parameter int W     = 16,
  parameter int PRE_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       presc_sel,
  input  logic             top_src_sel,
  input  logic             top_wr,
  input  logic [W-1:0]     top_wdata,
  input  logic [NCH-1:0]   cmp_wr,
  input  logic [NCH*W-1:0] cmp_wdata,
  input  logic [2*NCH-1:0] out_mode,
  input  logic [NCH-1:0]   match_clr,
  input  logic             top_flag_clr,
  input  logic             bot_flag_clr,
  output logic [W-1:0]     count_o,
  output logic             count_down_o,
  output logic [NCH-1:0]   pwm_o,
  output logic [NCH-1:0]   match_flag_o,
  output logic             top_flag_o,
  output logic             bot_flag_o
);
  logic         tick;
  logic [W-1:0] top_reg;
  logic [W-1:0] cnt;
  logic [W-1:0] top_cur;
  logic         dir_down;
  logic         load;
  logic         top_turn;
  logic         bot_turn;
  logic [W-1:0] ch_buf [NCH];

  pwm_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .sel  (presc_sel),
    .tick (tick)
  );

  always_ff @(posedge clk) begin
    if (rst)         top_reg <= '1;
    else if (top_wr) top_reg <= top_wdata;
  end

  pwm_updown_counter #(.W(W)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .top_src_sel (top_src_sel),
    .top_reg_val (top_reg),
    .cmpa_buf    (ch_buf[0]),
    .cnt         (cnt),
    .top_cur     (top_cur),
    .dir_down    (dir_down),
    .load        (load),
    .top_turn    (top_turn),
    .bot_turn    (bot_turn)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pwm_compare_ch #(.W(W)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .tick     (tick),
      .load     (load),
      .dir_down (dir_down),
      .cnt      (cnt),
      .top_cur  (top_cur),
      .wr       (cmp_wr[i]),
      .wdata    (cmp_wdata[i*W +: W]),
      .mode     (out_mode[2*i +: 2]),
      .flag_clr (match_clr[i]),
      .buf_q    (ch_buf[i]),
      .pin      (pwm_o[i]),
      .flag     (match_flag_o[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      top_flag_o <= 1'b0;
      bot_flag_o <= 1'b0;
    end else begin
      if (top_turn)          top_flag_o <= 1'b1;
      else if (top_flag_clr) top_flag_o <= 1'b0;
      if (bot_turn)          bot_flag_o <= 1'b1;
      else if (bot_flag_clr) bot_flag_o <= 1'b0;
    end
  end

  assign count_o      = cnt;
  assign count_down_o = dir_down;

  p_stopped_r3: assert property (@(posedge clk) disable iff (rst)
    (presc_sel == 3'd0) |=> $stable(count_o));

  p_top_flag_r11: assert property (@(posedge clk) disable iff (rst)
    top_turn |=> top_flag_o && count_down_o);

  p_bot_flag_r11: assert property (@(posedge clk) disable iff (rst)
    bot_turn |=> bot_flag_o && !count_down_o && count_o == W'(1));

endmodule

// File: tb/pwm_dual_slope_timer_tb_top.sv
`timescale 1ns/1ps
module pwm_dual_slope_timer_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  presc_sel = 3'd0;
  logic        top_src_sel = 1'b0;
  logic        top_wr = 1'b0;
  logic [15:0] top_wdata = '0;
  logic [1:0]  cmp_wr = '0;
  logic [31:0] cmp_wdata = '0;
  logic [3:0]  out_mode = '0;
  logic [1:0]  match_clr = '0;
  logic        top_flag_clr = 1'b0;
  logic        bot_flag_clr = 1'b0;
  logic [15:0] count_o;
  logic        count_down_o;
  logic [1:0]  pwm_o;
  logic [1:0]  match_flag_o;
  logic        top_flag_o;
  logic        bot_flag_o;

  int unsigned n_chk  = 0;
  int unsigned n_fail = 0;
  int unsigned cyc    = 0;

  always #2 clk = ~clk;

  pwm_dual_slope_timer dut_i (
    .clk(clk), .rst(rst), .presc_sel(presc_sel), .top_src_sel(top_src_sel),
    .top_wr(top_wr), .top_wdata(top_wdata), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
    .out_mode(out_mode), .match_clr(match_clr), .top_flag_clr(top_flag_clr),
    .bot_flag_clr(bot_flag_clr), .count_o(count_o), .count_down_o(count_down_o),
    .pwm_o(pwm_o), .match_flag_o(match_flag_o), .top_flag_o(top_flag_o),
    .bot_flag_o(bot_flag_o)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<=100000 cycles", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  typedef struct packed {
    logic        sel;
    logic [15:0] top;
    logic [15:0] a;
    logic [15:0] b;
    logic [1:0]  ma;
    logic [1:0]  mb;
    logic [31:0] ttop;
    logic [31:0] ea;
    logic [31:0] eb;
  } vec_t;

  // expected high clocks over two full periods (4*TOP clocks)
  localparam vec_t VECS [6] = '{
    '{1'b0, 16'd10,  16'd4,  16'd7,  2'd2, 2'd3, 32'd10, 32'd16, 32'd12},
    '{1'b0, 16'd10,  16'd0,  16'd0,  2'd2, 2'd3, 32'd10, 32'd0,  32'd40},
    '{1'b0, 16'd10,  16'd10, 16'd12, 2'd2, 2'd3, 32'd10, 32'd40, 32'd0},
    '{1'b1, 16'd100, 16'd8,  16'd3,  2'd1, 2'd2, 32'd8,  32'd16, 32'd12},
    '{1'b0, 16'd2,   16'd1,  16'd2,  2'd2, 2'd0, 32'd3,  32'd4,  32'd0},
    '{1'b0, 16'd6,   16'd5,  16'd1,  2'd1, 2'd3, 32'd6,  32'd4,  32'd20}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [1:0] md, input logic [15:0] c,
                                   input logic [31:0] t);
    if (md == 2'd0) return "R9";
    if (md == 2'd1) return "R8";
    if (c == 16'd0 || 32'(c) >= t) return "R7";
    if (md == 2'd2) return "R5";
    return "R6";
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    presc_sel = 3'd0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_state(input logic [15:0] v, input logic d);
    do @(negedge clk); while (!(count_o == v && count_down_o == d));
  endtask

  task automatic measure_gap(output int unsigned n);
    logic [15:0] prev;
    @(negedge clk);
    prev = count_o;
    do @(negedge clk); while (count_o == prev);
    prev = count_o;
    n = 0;
    do begin @(negedge clk); n++; end while (count_o == prev);
  endtask

  initial begin
    int unsigned gap;
    do_reset();

    // ---- table of waveform vectors ----
    for (int vi = 0; vi < 6; vi++) begin
      vec_t v;
      int unsigned hia, hib, peak, at_top;
      v = VECS[vi];
      do_reset();
      top_src_sel = v.sel;
      top_wdata   = v.top;
      top_wr      = 1'b1;
      cmp_wdata   = {v.b, v.a};
      cmp_wr      = 2'b11;
      out_mode    = {v.mb, v.ma};
      @(negedge clk);
      top_wr    = 1'b0;
      cmp_wr    = 2'b00;
      presc_sel = 3'd1;
      repeat (4 * v.ttop + 4) @(negedge clk);
      hia = 0; hib = 0; peak = 0; at_top = 0;
      for (int k = 0; k < 4 * int'(v.ttop); k++) begin
        @(negedge clk);
        hia += pwm_o[0];
        hib += pwm_o[1];
        if (count_o > peak) peak = count_o;
        if (count_o == v.ttop[15:0]) at_top++;
      end
      chk($sformatf("%s vec%0d pin0 high clocks", tag_of(v.ma, v.a, v.ttop), vi), hia, v.ea);
      chk($sformatf("%s vec%0d pin1 high clocks", tag_of(v.mb, v.b, v.ttop), vi), hib, v.eb);
      chk($sformatf("R2 vec%0d peak count", vi), peak, v.ttop);
      chk($sformatf("R1 vec%0d clocks at TOP in two periods", vi), at_top, 32'd2);
    end

    // ---- R3 prescaler ----
    do_reset();
    top_src_sel = 1'b0;
    top_wdata = 16'd500;
    top_wr = 1'b1;
    @(negedge clk);
    top_wr = 1'b0;
    presc_sel = 3'd2;
    measure_gap(gap);
    chk("R3 divide-by-8 tick gap", gap, 32'd8);
    presc_sel = 3'd3;
    measure_gap(gap);
    measure_gap(gap);
    chk("R3 divide-by-64 tick gap", gap, 32'd64);
    presc_sel = 3'd0;
    begin
      logic [15:0] held;
      @(negedge clk);
      held = count_o;
      repeat (40) @(negedge clk);
      chk("R3 stopped counter holds", 32'(count_o), 32'(held));
    end

    // ---- R4 buffered compare take-up ----
    do_reset();
    top_src_sel = 1'b0;
    top_wdata = 16'd10;
    top_wr = 1'b1;
    cmp_wdata = {16'd5, 16'd4};
    cmp_wr = 2'b11;
    out_mode = {2'd0, 2'd2};
    @(negedge clk);
    top_wr = 1'b0;
    cmp_wr = 2'b00;
    presc_sel = 3'd1;
    repeat (45) @(negedge clk);
    wait_state(16'd2, 1'b0);
    cmp_wdata = {16'd5, 16'd8};
    cmp_wr = 2'b01;
    @(negedge clk);
    cmp_wr = 2'b00;
    wait_state(16'd6, 1'b0);
    chk("R4 old compare still live before bottom", 32'(pwm_o[0]), 32'd0);
    wait_state(16'd0, 1'b1);
    wait_state(16'd6, 1'b0);
    chk("R4 new compare live after bottom", 32'(pwm_o[0]), 32'd1);

    // ---- R10 / R11 flags ----
    presc_sel = 3'd0;
    @(negedge clk);
    chk("R10 match flags set", 32'(match_flag_o), 32'd3);
    chk("R11 top flag set", 32'(top_flag_o), 32'd1);
    chk("R11 bottom flag set", 32'(bot_flag_o), 32'd1);
    match_clr = 2'b11;
    top_flag_clr = 1'b1;
    bot_flag_clr = 1'b1;
    @(negedge clk);
    match_clr = 2'b00;
    top_flag_clr = 1'b0;
    bot_flag_clr = 1'b0;
    chk("R10 match flags cleared", 32'(match_flag_o), 32'd0);
    chk("R11 turn flags cleared", 32'({top_flag_o, bot_flag_o}), 32'd0);
    repeat (5) @(negedge clk);
    chk("R10 cleared flags stay clear while stopped", 32'(match_flag_o), 32'd0);

    // ---- R12 reset ----
    presc_sel = 3'd1;
    repeat (7) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R12 count and direction after reset", 32'({count_down_o, count_o}), 32'd0);
    chk("R12 pins and flags after reset",
        32'({pwm_o, match_flag_o, top_flag_o, bot_flag_o}), 32'd0);
    rst = 1'b0;
    presc_sel = 3'd0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule